// File: doc/BRIEF.md
# Active Priority Bitmap Tracker

This block records which preemption priority levels are currently in service on one processor interface of an interrupt controller. It keeps a separate bitmap for each of three interrupt groups. Acknowledging an interrupt sets the bit for its group priority. A priority drop for a group clears the highest-priority active level of that group. From the union of all three bitmaps the block continuously derives the running priority, which is the numerically lowest active level, or the idle value 0xFF when nothing is active.

The number of implemented priority bits, `PRIO_BITS`, is a build parameter in the range 4 to 8. The preemption bit count `PB` equals `PRIO_BITS`, except that 8 priority bits give 7 preemption bits. `PB` sets how many 32-bit bitmap words each group has and how a priority maps onto a bit. A word-addressed register port lets software save and restore each bitmap word. The surrounding controller chooses which interrupt to acknowledge and supplies its priority already masked to the group.

Top module: `aprt_active_prio`

## Requirements
- R1: After synchronous reset every bitmap word of every group reads zero and `run_prio` is 0xFF.
- R2: Each group implements 1 << max(PB − 5, 0) words, so 1, 2 or 4 words. A `reg_word` index at or above that count reads zero, and a write to it changes nothing.
- R3: An activate strobe with `act_group` 0, 1 or 2 sets bit index `act_prio >> (8 − PB)` in that group. The word is index/32 and the bit is index%32. The low `8 − PB` bits of `act_prio` are ignored, and `act_group` 3 is ignored.
- R4: `run_prio` is taken from the OR of the three groups' words, scanning from word 0 upward. It equals (word × 32 + position of the lowest set bit) shifted left by `8 − PB`, truncated to 8 bits. It is 0xFF when no implemented bit is set.
- R5: A drop strobe for group 0, 1 or 2 clears only the lowest set bit of the first nonzero implemented word of that group.
- R6: A drop for a group whose words are all zero changes no state.
- R7: A register write to an implemented word of group 0, 1 or 2 replaces the whole word. In the same cycle it takes precedence over any activate or drop on that group.
- R8: The bitmaps are registered and `run_prio` is combinational from them, so an activate, drop or write shows on `run_prio` and `reg_rdata` after the next rising clock edge.
- R9: An activate or drop on one group never changes the words of another group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_valid | input | 1 | Activate strobe |
| act_group | input | 2 | Group of the acknowledged interrupt (0, 1, 2; 3 = none) |
| act_prio | input | 8 | Group-masked priority of the acknowledged interrupt |
| drop_valid | input | 1 | Priority drop strobe |
| drop_group | input | 2 | Group whose priority is dropped |
| reg_wr | input | 1 | Bitmap word write strobe |
| reg_group | input | 2 | Group addressed by the register port |
| reg_word | input | 2 | Word index addressed by the register port |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word (combinational) |
| run_prio | output | 8 | Running priority, 0xFF when idle |

## Verification
The bench is built with six priority bits, which gives two words per group. Every one of the 64 levels is activated alone in each group. Each time the running priority, the word and bit that were set, and the same word of a neighbour group are checked, and then the level is dropped again. Because the low priority bits are filled with junk, this sweep also shows that they are ignored. Stacked activations across groups and within one group separate the cross-group minimum from the per-group drop order. A drop on an empty group is checked for changing nothing. Writes to implemented and unimplemented words, a write that collides with an activate, and an activate to the invalid group each separate one of the corner rules.

// File: rtl/aprt_pkg.sv
package aprt_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        GRP_ZERO = 2'd0,
        GRP_ONE  = 2'd1,
        GRP_TWO  = 2'd2,
        GRP_NONE = 2'd3
    } grp_e;

    typedef struct packed {
        logic       valid;
        grp_e       grp;
        logic [7:0] prio;
    } act_req_t;

    typedef struct packed {
        logic valid;
        grp_e grp;
    } drop_req_t;

    typedef struct packed {
        logic              wr;
        grp_e              grp;
        logic [1:0]        word;
        logic [WORD_W-1:0] data;
    } reg_req_t;

    function automatic int preempt_bits(int pri);
        return (pri == 8) ? 7 : pri;
    endfunction

    function automatic int word_count(int pri);
        int pb;
        pb = preempt_bits(pri);
        return (pb > 5) ? (1 << (pb - 5)) : 1;
    endfunction

    function automatic int prio_shift(int pri);
        return 8 - preempt_bits(pri);
    endfunction

    function automatic logic [4:0] lowest_bit(logic [WORD_W-1:0] w);
        logic [4:0] r;
        r = '0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (w[i]) r = 5'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/aprt_group_bank.sv
module aprt_group_bank
    import aprt_pkg::*;
#(
    parameter int PRIO_BITS = 8,
    parameter int GID       = 0
) (
    input  logic      clk,
    input  logic      rst,
    input  act_req_t  act,
    input  drop_req_t drop,
    input  reg_req_t  wreq,
    output logic [word_count(PRIO_BITS)-1:0][WORD_W-1:0] words
);
    localparam int         NW    = word_count(PRIO_BITS);
    localparam int         SHIFT = prio_shift(PRIO_BITS);
    localparam logic [1:0] GCODE = 2'(GID);

    logic [NW-1:0][WORD_W-1:0] nxt;
    logic [7:0] act_idx;
    logic       hit_act;
    logic       hit_drop;
    logic       hit_wr;
    logic       dropped;

    assign act_idx  = act.prio >> SHIFT;
    assign hit_act  = act.valid  && (act.grp  == grp_e'(GCODE));
    assign hit_drop = drop.valid && (drop.grp == grp_e'(GCODE));
    assign hit_wr   = wreq.wr    && (wreq.grp == grp_e'(GCODE));

    always_comb begin
        nxt     = words;
        dropped = 1'b0;
        if (hit_drop) begin
            for (int i = 0; i < NW; i++) begin
                if (!dropped && (words[i] != '0)) begin
                    nxt[i]  = words[i] & (words[i] - 32'd1);
                    dropped = 1'b1;
                end
            end
        end
        if (hit_act) begin
            for (int i = 0; i < NW; i++) begin
                if (int'(act_idx[7:5]) == i) nxt[i][act_idx[4:0]] = 1'b1;
            end
        end
        if (hit_wr) begin
            for (int i = 0; i < NW; i++) begin
                if (int'(wreq.word) == i) nxt[i] = wreq.data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) words <= '0;
        else     words <= nxt;
    end

endmodule

// File: rtl/aprt_prio_scan.sv
module aprt_prio_scan
    import aprt_pkg::*;
#(
    parameter int PRIO_BITS = 8
) (
    input  logic [2:0][word_count(PRIO_BITS)-1:0][WORD_W-1:0] banks,
    output logic [7:0] run_prio
);
    localparam int NW    = word_count(PRIO_BITS);
    localparam int SHIFT = prio_shift(PRIO_BITS);

    logic [WORD_W-1:0] merged;
    logic              found;
    int                idx;

    always_comb begin
        run_prio = 8'hFF;
        found    = 1'b0;
        merged   = '0;
        idx      = 0;
        for (int i = 0; i < NW; i++) begin
            merged = banks[0][i] | banks[1][i] | banks[2][i];
            if (!found && (merged != '0)) begin
                idx      = 32 * i + int'(lowest_bit(merged));
                run_prio = 8'(idx << SHIFT);
                found    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/aprt_active_prio.sv
module aprt_active_prio
    import aprt_pkg::*;
#(
    parameter int PRIO_BITS = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        act_valid,
    input  logic [1:0]  act_group,
    input  logic [7:0]  act_prio,
    input  logic        drop_valid,
    input  logic [1:0]  drop_group,
    input  logic        reg_wr,
    input  logic [1:0]  reg_group,
    input  logic [1:0]  reg_word,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic [7:0]  run_prio
);
    localparam int NW = word_count(PRIO_BITS);

    act_req_t  act_req;
    drop_req_t drop_req;
    reg_req_t  wr_req;
    logic [2:0][NW-1:0][WORD_W-1:0] banks;

    assign act_req.valid  = act_valid;
    assign act_req.grp    = grp_e'(act_group);
    assign act_req.prio   = act_prio;
    assign drop_req.valid = drop_valid;
    assign drop_req.grp   = grp_e'(drop_group);
    assign wr_req.wr      = reg_wr;
    assign wr_req.grp     = grp_e'(reg_group);
    assign wr_req.word    = reg_word;
    assign wr_req.data    = reg_wdata;

    for (genvar g = 0; g < 3; g++) begin : g_bank
        aprt_group_bank #(
            .PRIO_BITS(PRIO_BITS),
            .GID      (g)
        ) u_bank (
            .clk  (clk),
            .rst  (rst),
            .act  (act_req),
            .drop (drop_req),
            .wreq (wr_req),
            .words(banks[g])
        );
    end

    aprt_prio_scan #(
        .PRIO_BITS(PRIO_BITS)
    ) u_scan (
        .banks   (banks),
        .run_prio(run_prio)
    );

    always_comb begin
        reg_rdata = '0;
        for (int g = 0; g < 3; g++) begin
            for (int i = 0; i < NW; i++) begin
                if ((int'(reg_group) == g) && (int'(reg_word) == i)) reg_rdata = banks[g][i];
            end
        end
    end

endmodule

// File: rtl/aprt_checks.sv
module aprt_checks
    import aprt_pkg::*;
#(
    parameter int PRIO_BITS = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        act_valid,
    input logic [1:0]  act_group,
    input logic [7:0]  act_prio,
    input logic        drop_valid,
    input logic        reg_wr,
    input logic [1:0]  reg_group,
    input logic [1:0]  reg_word,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic [7:0]  run_prio
);
    localparam int         NW      = word_count(PRIO_BITS);
    localparam int         SH      = prio_shift(PRIO_BITS);
    localparam logic [7:0] LOWMASK = 8'((1 << SH) - 1);

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> run_prio == 8'hFF);                                  // R1

    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (int'(reg_word) >= NW) |-> reg_rdata == 32'd0);                     // R2

    AST_ACT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (act_valid && act_group != 2'd3 && !drop_valid && !reg_wr)
        |=> run_prio <= ((($past(act_prio)) >> SH) << SH));                 // R3

    AST_INVALID_GROUP: assert property (@(posedge clk) disable iff (rst)
        (act_valid && act_group == 2'd3 && !drop_valid && !reg_wr)
        |=> $stable(run_prio));                                            // R3

    AST_RUN_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (run_prio == 8'hFF) || ((run_prio & LOWMASK) == 8'd0));             // R4

    AST_DROP_RAISES: assert property (@(posedge clk) disable iff (rst)
        (drop_valid && !act_valid && !reg_wr) |=> run_prio >= $past(run_prio)); // R5

    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_group != 2'd3 && int'(reg_word) < NW)
        |=> (!$stable(reg_group) || !$stable(reg_word) || reg_rdata == $past(reg_wdata))); // R7

endmodule

bind aprt_active_prio aprt_checks #(.PRIO_BITS(PRIO_BITS)) u_chk (.*);

// File: tb/aprt_active_prio_test.sv
module aprt_active_prio_test;
    localparam int CLK_PERIOD = 10;
    localparam int PRIO_BITS  = 6;
    localparam int SH         = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        act_valid = 1'b0;
    logic [1:0]  act_group = '0;
    logic [7:0]  act_prio = '0;
    logic        drop_valid = 1'b0;
    logic [1:0]  drop_group = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_group = '0;
    logic [1:0]  reg_word = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  run_prio;

    int n_vec = 0;
    int n_bad = 0;

    aprt_active_prio #(.PRIO_BITS(PRIO_BITS)) uut (
        .clk(clk), .rst(rst),
        .act_valid(act_valid), .act_group(act_group), .act_prio(act_prio),
        .drop_valid(drop_valid), .drop_group(drop_group),
        .reg_wr(reg_wr), .reg_group(reg_group), .reg_word(reg_word),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .run_prio(run_prio)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        act_valid  = 1'b0;
        drop_valid = 1'b0;
        reg_wr     = 1'b0;
    endtask

    task automatic activate(input int g, input int p);
        act_valid = 1'b1; act_group = 2'(g); act_prio = 8'(p);
        step();
    endtask

    task automatic drop(input int g);
        drop_valid = 1'b1; drop_group = 2'(g);
        step();
    endtask

    task automatic wr(input int g, input int w, input logic [31:0] d);
        reg_wr = 1'b1; reg_group = 2'(g); reg_word = 2'(w); reg_wdata = d;
        step();
    endtask

    task automatic rd(input int g, input int w, output logic [31:0] d);
        reg_group = 2'(g); reg_word = 2'(w);
        #1;
        d = reg_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not complete (all requirements) actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        check("R1 run_prio after reset", 32'(run_prio), 32'hFF);
        for (int g = 0; g < 3; g++) begin
            for (int w = 0; w < 4; w++) begin
                rd(g, w, d);
                check("R1 word zero after reset", d, 32'd0);
            end
        end

        // R3 R4 R5 R8 R9: every level alone in every group, junk in low bits
        for (int g = 0; g < 3; g++) begin
            for (int l = 0; l < 64; l++) begin
                activate(g, l * 4 + (l % 4));
                check("R4 R8 run_prio single level", 32'(run_prio), 32'(l << SH));
                rd(g, l / 32, d);
                check("R3 bit placement", d, 32'd1 << (l % 32));
                rd((g + 1) % 3, l / 32, d);
                check("R9 other group untouched", d, 32'd0);
                drop(g);
                check("R5 drop back to idle", 32'(run_prio), 32'hFF);
            end
        end

        // R4: minimum across groups; R5 drops per group
        activate(1, 40 * 4);
        activate(0, 10 * 4);
        activate(2, 33 * 4);
        check("R4 min across groups", 32'(run_prio), 32'd40);
        drop(0);
        check("R4 next after group0 drop", 32'(run_prio), 32'd132);
        drop(1);
        check("R5 group1 drop leaves group2", 32'(run_prio), 32'd132);
        drop(2);
        check("R4 idle after all drops", 32'(run_prio), 32'hFF);

        // R5: drop order inside one group, across words
        activate(1, 5 * 4);
        activate(1, 50 * 4);
        check("R4 two levels one group", 32'(run_prio), 32'd20);
        drop(1);
        check("R5 lowest level dropped first", 32'(run_prio), 32'd200);
        rd(1, 1, d);
        check("R5 upper word kept", d, 32'd1 << 18);
        drop(1);

        // R5: two bits in one word
        activate(0, 9 * 4);
        activate(0, 3 * 4);
        drop(0);
        rd(0, 0, d);
        check("R5 lowest bit cleared in word", d, 32'd1 << 9);
        drop(0);

        // R6: drop on empty group
        activate(2, 7 * 4);
        drop(0);
        rd(2, 0, d);
        check("R6 empty drop keeps group2", d, 32'd1 << 7);
        rd(0, 0, d);
        check("R6 empty group stays zero", d, 32'd0);
        check("R6 run_prio unchanged", 32'(run_prio), 32'd28);
        drop(2);

        // R7, R2: register writes
        wr(2, 1, 32'h0000_0100);
        rd(2, 1, d);
        check("R7 write readback", d, 32'h0000_0100);
        check("R7 run_prio from written word", 32'(run_prio), 32'd160);
        wr(0, 2, 32'hFFFF_FFFF);
        rd(0, 2, d);
        check("R2 unimplemented word reads zero", d, 32'd0);
        rd(0, 3, d);
        check("R2 unimplemented word 3 reads zero", d, 32'd0);
        check("R2 run_prio unaffected", 32'(run_prio), 32'd160);
        wr(2, 1, 32'd0);
        check("R7 cleared by write", 32'(run_prio), 32'hFF);

        // R7: write wins over activate on same group
        act_valid = 1'b1; act_group = 2'd1; act_prio = 8'(3 * 4);
        reg_wr = 1'b1; reg_group = 2'd1; reg_word = 2'd0; reg_wdata = 32'd1 << 20;
        step();
        rd(1, 0, d);
        check("R7 write precedence", d, 32'd1 << 20);
        check("R7 run_prio after collision", 32'(run_prio), 32'd80);
        wr(1, 0, 32'd0);

        // R3: group 3 ignored
        activate(3, 40);
        check("R3 invalid group ignored", 32'(run_prio), 32'hFF);
        for (int g = 0; g < 3; g++) begin
            rd(g, 0, d);
            check("R3 invalid group no bit", d, 32'd0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule